// File: doc/BRIEF.md
# Skip-Code Scan Sequencer

This block sits between a single serial test input and a two-dimensional segment selector that chooses one short scan segment out of a grid of columns and rows. It decides, cycle by cycle, whether the bits arriving on the scan input are data for the selected segment or commands that move the selection. It drives a shift enable for the selected segment and the column and row advance strobes of the selector. It raises a done flag once the selection has moved past the final segment.

A start pulse begins a pattern and latches the operating mode. In regular mode every segment is loaded in order, SEG_LEN data cycles each, followed by one advance cycle. In skipping mode each segment first takes a two-bit command from the stream. A load command is followed by the segment's data. A skip command costs a single advance cycle and no data, so runs of segments whose content does not matter take only command and advance cycles. The sequencer keeps its own copy of the selector position so that it knows when a column wraps and when the pattern ends.

Top module: `skipscan_seq`

## Requirements
- R1: Out of reset, and in idle until a start pulse arrives, shift_en, col_adv, row_adv and done are all low.
- R2: skip_mode is sampled only in the cycle that start is taken in idle; changes to skip_mode during a pattern have no effect on that pattern.
- R3: In regular mode, after start each segment gets exactly SEG_LEN cycles with shift_en high followed by exactly one cycle with col_adv high; no command bits are read.
- R4: In skipping mode the two scan_in bits sampled in the two cycles before a segment's data or advance form its command, the first bit received being the left digit of the code; shift_en, col_adv and done are low in both command cycles.
- R5: Outside a skip run, a command whose second bit is 0 (code 00, or 10) loads the segment: SEG_LEN shift_en cycles and then one col_adv cycle.
- R6: A command whose second bit is 1 skips the segment: the cycle right after the command has col_adv high, with no shift_en cycle for that segment.
- R7: Code 11 opens a skip run: the next command is taken as a skip whatever its value, and continues the run only if its first bit is 1. Code 01 is a single skip or the last skip of a run. A new pattern always starts outside a run.
- R8: row_adv is high together with col_adv exactly when the selection is in the last column (NCOL-1); the column position then returns to 0. Positions start at column 0, row 0 on every start.
- R9: done is high for exactly one cycle, the cycle after the advance out of the last segment (column NCOL-1, row NROW-1); the block then returns to idle and a new start begins a fresh pattern.
- R10: A start pulse while a pattern is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pattern (taken in idle only) |
| skip_mode | input | 1 | 1 = command-driven skipping mode, 0 = regular mode; latched at start |
| scan_in | input | 1 | Serial test stream (commands and data) |
| shift_en | output | 1 | Shift the selected segment this cycle |
| col_adv | output | 1 | Advance the column position of the selector |
| row_adv | output | 1 | Advance the row position (with a column wrap) |
| done | output | 1 | One-cycle flag: the last segment has been passed |

## Verification
The bench goes after the column wrap taken by a skip rather than by a load, where a design that only checks the wrap after data would leave the row stuck and miscount the end of the pattern. It feeds code 00 straight after code 11, which a decoder without run memory would treat as a load and then shift data into a segment meant to be skipped. It toggles skip_mode and pulses start in mid-pattern, which a design that reads the mode pin live or restarts on any start would follow. It also runs a pattern that ends inside a skip run, so a run state that is not cleared at start would turn the next pattern's first load into a skip.

// File: rtl/skipscan_pkg.sv
package skipscan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CODE_HI = 3'd1,
      ST_CODE_LO = 3'd2,
      ST_LOAD    = 3'd3,
      ST_STEP    = 3'd4,
      ST_FIN     = 3'd5
   } seq_state_t;

endpackage

// File: rtl/skipscan_code_dec.sv
module skipscan_code_dec (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic take_hi,
   input  logic take_lo,
   input  logic bit_in,
   output logic skip
);

   logic hi_q;
   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
      end else if (take_hi) begin
         hi_q <= bit_in;
      end
   end

   // Skip if a run is open or the second code bit is 1.
   assign skip = run_q | bit_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (clear) begin
         run_q <= 1'b0;
      end else if (take_lo) begin
         run_q <= skip & hi_q;
      end
   end

   // R7: a run opens only after a first code bit of 1
   a_r7_run_from_hi: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(hi_q));

endmodule

// File: rtl/skipscan_beat_cnt.sv
module skipscan_beat_cnt #(
   parameter int SEG_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   generate
      if (SEG_LEN < 1) begin : g_bad_len
         $error("SEG_LEN must be at least 1");
      end

      if (SEG_LEN == 1) begin : g_single
         assign last = run;
      end else begin : g_count
         localparam int CNT_W = $clog2(SEG_LEN);
         localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SEG_LEN - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (run) begin
               cnt_q <= (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
            end
         end

         assign last = run && (cnt_q == CNT_TOP);

         // R3: beat count never exceeds the segment length
         a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_TOP);
         // R3: counter is back at zero whenever the load phase is not running
         a_r3_cnt_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !run |-> cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/skipscan_pos_track.sv
module skipscan_pos_track #(
   parameter int NCOL = 4,
   parameter int NROW = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic col_end,
   output logic at_last
);

   localparam int CW = (NCOL > 1) ? $clog2(NCOL) : 1;
   localparam logic [CW-1:0] COL_TOP = CW'(NCOL - 1);

   logic [CW-1:0] col_q;
   logic          row_end;

   generate
      if (NCOL < 2) begin : g_bad_col
         $error("NCOL must be at least 2");
      end
      if (NROW < 1) begin : g_bad_row
         $error("NROW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
      end else if (clear) begin
         col_q <= '0;
      end else if (step) begin
         col_q <= col_end ? '0 : col_q + 1'b1;
      end
   end

   assign col_end = (col_q == COL_TOP);

   generate
      if (NROW > 1) begin : g_rows
         localparam int RW = $clog2(NROW);
         localparam logic [RW-1:0] ROW_TOP = RW'(NROW - 1);
         logic [RW-1:0] row_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= '0;
            end else if (clear) begin
               row_q <= '0;
            end else if (step && col_end) begin
               row_q <= row_end ? '0 : row_q + 1'b1;
            end
         end

         assign row_end = (row_q == ROW_TOP);

         // R8: a step out of a non-final row's last column moves the row on
         a_r8_row_moves: assert property (@(posedge clk) disable iff (!rst_n)
            (step && col_end && !row_end && !clear) |=> row_q == $past(row_q) + 1'b1);
      end else begin : g_one_row
         assign row_end = 1'b1;
      end
   endgenerate

   assign at_last = col_end & row_end;

   // R8: a step taken in the last column wraps the column to zero
   a_r8_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && col_end) |=> col_q == '0);

endmodule

// File: rtl/skipscan_seq.sv
module skipscan_seq #(
   parameter int NCOL    = 4,
   parameter int NROW    = 3,
   parameter int SEG_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic skip_mode,
   input  logic scan_in,
   output logic shift_en,
   output logic col_adv,
   output logic row_adv,
   output logic done
);

   import skipscan_pkg::*;

   seq_state_t state_q, state_d;
   logic       mode_q;
   logic       begin_pat;
   logic       code_skip;
   logic       beat_last;
   logic       col_end;
   logic       at_last;

   assign begin_pat = (state_q == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
      end else if (begin_pat) begin
         mode_q <= skip_mode;
      end
   end

   skipscan_code_dec u_code (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (begin_pat),
      .take_hi (state_q == ST_CODE_HI),
      .take_lo (state_q == ST_CODE_LO),
      .bit_in  (scan_in),
      .skip    (code_skip)
   );

   skipscan_beat_cnt #(.SEG_LEN(SEG_LEN)) u_beats (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == ST_LOAD),
      .last  (beat_last)
   );

   skipscan_pos_track #(.NCOL(NCOL), .NROW(NROW)) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (begin_pat),
      .step    (state_q == ST_STEP),
      .col_end (col_end),
      .at_last (at_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start) state_d = skip_mode ? ST_CODE_HI : ST_LOAD;
         ST_CODE_HI: state_d = ST_CODE_LO;
         ST_CODE_LO: state_d = code_skip ? ST_STEP : ST_LOAD;
         ST_LOAD:    if (beat_last) state_d = ST_STEP;
         ST_STEP: begin
            if (at_last)     state_d = ST_FIN;
            else if (mode_q) state_d = ST_CODE_HI;
            else             state_d = ST_LOAD;
         end
         ST_FIN:     state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign shift_en = (state_q == ST_LOAD);
   assign col_adv  = (state_q == ST_STEP);
   assign row_adv  = (state_q == ST_STEP) && col_end;
   assign done     = (state_q == ST_FIN);

   // R3: the end of a load phase is always followed by an advance
   a_r3_load_then_adv: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_en) |-> col_adv);
   // R6: an advance never lasts more than one cycle
   a_r6_single_adv: assert property (@(posedge clk) disable iff (!rst_n)
      col_adv |=> !col_adv);
   // R9: done is a single pulse followed by idle outputs
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !shift_en && !col_adv);
   // R2: latched mode holds while a pattern runs
   a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(mode_q));
   // R8: a row strobe never comes without a column strobe
   a_r8_row_with_col: assert property (@(posedge clk) disable iff (!rst_n)
      row_adv |-> col_adv);

endmodule

// File: tb/skipscan_seq_test.sv
`timescale 1ns/1ps
module skipscan_seq_test;

   localparam int NCOL    = 4;
   localparam int NROW    = 3;
   localparam int SEG_LEN = 5;
   localparam int NSEG    = NCOL * NROW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic skip_mode = 1'b0;
   logic scan_in = 1'b0;
   logic shift_en, col_adv, row_adv, done;

   int checks = 0;
   int errors = 0;

   bit code_hi [NSEG];
   bit code_lo [NSEG];

   always #2.5 clk = ~clk;

   skipscan_seq #(.NCOL(NCOL), .NROW(NROW), .SEG_LEN(SEG_LEN)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .skip_mode(skip_mode),
      .scan_in(scan_in), .shift_en(shift_en), .col_adv(col_adv),
      .row_adv(row_adv), .done(done)
   );

   task automatic check_out(input logic [3:0] exp, input string tag);
      logic [3:0] act;
      act = {shift_en, col_adv, row_adv, done};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {shift_en,col_adv,row_adv,done} actual %b expected %b at %0t",
                  tag, act, exp, $time);
      end
   endtask

   // One cycle: check the current outputs, then drive the inputs consumed by this state.
   task automatic cyc(input logic si, input logic st, input logic md,
                      input logic [3:0] exp, input string tag);
      @(negedge clk);
      check_out(exp, tag);
      scan_in   = si;
      start     = st;
      skip_mode = md;
   endtask

   // noise: random start pulses and mode flips during the pattern (R2, R10)
   task automatic run_pat(input bit mode, input bit noise);
      int col = 0;
      int row = 0;
      bit run = 1'b0;
      logic ns, nm;
      cyc(1'b0, 1'b1, mode, 4'b0000, "R1 idle before start");
      for (int s = 0; s < NSEG; s++) begin
         bit sk = 1'b0;
         if (mode) begin
            ns = noise ? 1'($urandom_range(1)) : 1'b0;
            nm = noise ? 1'($urandom_range(1)) : mode;
            cyc(code_hi[s], ns, nm, 4'b0000, "R4 first code cycle");
            ns = noise ? 1'($urandom_range(1)) : 1'b0;
            nm = noise ? 1'($urandom_range(1)) : mode;
            cyc(code_lo[s], ns, nm, 4'b0000, "R4 second code cycle");
            sk  = run | code_lo[s];
            run = sk & code_hi[s];
         end
         if (!sk) begin
            for (int b = 0; b < SEG_LEN; b++) begin
               ns = noise ? 1'($urandom_range(1)) : 1'b0;
               nm = noise ? 1'($urandom_range(1)) : mode;
               cyc(1'($urandom_range(1)), ns, nm, 4'b1000,
                   mode ? "R5 load beat" : "R3 regular beat");
            end
         end
         ns = noise ? 1'($urandom_range(1)) : 1'b0;
         nm = noise ? 1'($urandom_range(1)) : mode;
         cyc(1'($urandom_range(1)), ns, nm, {1'b0, 1'b1, (col == NCOL-1), 1'b0},
             sk ? "R6 R8 skip advance" : "R8 advance after load");
         if (col == NCOL-1) begin
            col = 0;
            row = row + 1;
         end else begin
            col = col + 1;
         end
      end
      cyc(1'b0, 1'b0, mode, 4'b0001, "R9 done pulse");
      cyc(1'b0, 1'b0, mode, 4'b0000, "R9 back to idle");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_out(4'b0000, "R1 in reset");
      rst_n = 1'b1;
      // idle with no start: nothing moves
      for (int i = 0; i < 4; i++) cyc(1'($urandom_range(1)), 1'b0, 1'($urandom_range(1)), 4'b0000, "R1 idle");

      // regular mode, quiet and noisy
      run_pat(1'b0, 1'b0);
      run_pat(1'b0, 1'b1);

      // skipping mode: all loads, alternating 00 and 10
      for (int s = 0; s < NSEG; s++) begin code_hi[s] = s[0]; code_lo[s] = 1'b0; end
      run_pat(1'b1, 1'b0);

      // skipping mode: one long run 11..11 01 crossing every wrap
      for (int s = 0; s < NSEG; s++) begin code_hi[s] = (s != NSEG-1); code_lo[s] = 1'b1; end
      run_pat(1'b1, 1'b0);

      // R7: 11 followed by 00 is a skip; skip run ending at a column wrap; pattern ends in a run
      for (int s = 0; s < NSEG; s++) begin code_hi[s] = 1'b0; code_lo[s] = 1'b0; end
      code_hi[1] = 1'b1; code_lo[1] = 1'b1;
      code_hi[2] = 1'b0; code_lo[2] = 1'b0;
      code_hi[3] = 1'b0; code_lo[3] = 1'b1;
      code_hi[NSEG-1] = 1'b1; code_lo[NSEG-1] = 1'b1;
      run_pat(1'b1, 1'b1);
      // R7: next pattern starts outside a run (first 00 must load)
      for (int s = 0; s < NSEG; s++) begin code_hi[s] = 1'b0; code_lo[s] = 1'b0; end
      run_pat(1'b1, 1'b0);

      // random mixes
      for (int p = 0; p < 30; p++) begin
         for (int s = 0; s < NSEG; s++) begin
            code_hi[s] = 1'($urandom_range(1));
            code_lo[s] = 1'($urandom_range(1));
         end
         run_pat(1'($urandom_range(1)), 1'($urandom_range(1)));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: run did not complete, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule